// File: doc/BRIEF.md
# Floating-Point Exception Accumulate and Trap Unit

This unit sits at the retirement end of a floating-point pipeline. For every completed operation the pipeline presents the exception flags it raised, a per-instruction mask of exception classes to ignore, the number of the destination register, and a mode bit. The mode bit selects either plain raising or software-completion raising. The unit merges the flags into a sticky status register. It then decides whether the operation must take an arithmetic trap. When a trap is taken it emits a single-cycle pulse that carries an exception summary and a one-hot mask of the destination register.

The two modes differ in the order of their steps. In plain mode every raised flag becomes sticky, and only the trap decision honours the ignore mask. In software-completion mode the ignore mask is removed before anything becomes sticky. The surviving flags must also be enabled in a trap-enable register before they can trap, and the summary carries an extra software-completion tag. A byte-wide write port lets the sticky status and the trap-enable register be loaded directly.

Top module: `fpx_trap_unit`

## Requirements
- R1: After reset the sticky status, the trap-enable register, `trap_valid`, `trap_summary` and `trap_regmask` are all zero.
- R2: A plain-mode raise (`raise_swc`=0) ORs all pending flags into the sticky status, ignoring `raise_ignore`. The flag bits are: bit0 invalid, bit1 divide-by-zero, bit2 overflow, bit3 underflow, bit4 inexact, bit5 integer overflow. A status bit clears only through the write port.
- R3: A plain-mode raise traps when `raise_flags & ~raise_ignore` is nonzero. `trap_summary[5:0]` equals that value, and `trap_summary[6]`, the software-completion tag, is 0.
- R4: A software-completion raise (`raise_swc`=1) ORs only `raise_flags & ~raise_ignore` into the sticky status.
- R5: A software-completion raise traps only when `raise_flags & ~raise_ignore & enable` is nonzero. `trap_summary[5:0]` equals that value and `trap_summary[6]` is 1. When the gated value is zero, the status is still updated but no trap is issued.
- R6: On a trap, `trap_regmask` is one-hot with bit `raise_reg` set.
- R7: A raise with all pending flags zero changes no register and issues no trap, in either mode.
- R8: `trap_valid` is high for exactly one cycle, in the cycle after the clock edge that accepted the raise. While it is low, `trap_summary` and `trap_regmask` are zero. Raises on consecutive cycles give traps on consecutive cycles.
- R9: A write (`wr_en`=1) loads `wr_data[5:0]` into the sticky status when `wr_sel`=0, or into the trap-enable register when `wr_sel`=1. `wr_data[7:6]` are ignored.
- R10: When a status write and a raise occur in the same cycle, the new status is the written value ORed with the raise's sticky bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_valid | input | 1 | A completed operation presents its flags this cycle |
| raise_swc | input | 1 | 1 = software-completion mode, 0 = plain mode |
| raise_flags | input | 6 | Pending exception flags |
| raise_ignore | input | 6 | Exception classes this instruction ignores |
| raise_reg | input | 5 | Destination register number |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = sticky status, 1 = trap enable |
| wr_data | input | 8 | Write data, low six bits used |
| status_o | output | 6 | Sticky status register |
| enable_o | output | 6 | Trap-enable register |
| trap_valid | output | 1 | Trap pulse |
| trap_summary | output | 7 | Exception summary, bit 6 = software-completion tag |
| trap_regmask | output | 32 | One-hot destination register mask |

## Verification
A wrong sticky bit appears on `status_o` one cycle after the raise or write that caused it. It persists until software rewrites the register. A wrong trap-enable value shows up only on a later software-completion raise, as a missing trap or as extra summary bits. A fault in the mode ordering shows one cycle after the raise: either ignored classes become sticky in software-completion mode, or ignored classes go missing from the status in plain mode. The trap pulse, summary and register mask are all registered together, so any disagreement between them is visible in the same cycle as the pulse.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    // exception class bit positions, shared by status, enable and summary
    localparam int FPX_NCLS   = 6;
    localparam int FPX_INV    = 0;
    localparam int FPX_DZE    = 1;
    localparam int FPX_OVF    = 2;
    localparam int FPX_UNF    = 3;
    localparam int FPX_INE    = 4;
    localparam int FPX_IOV    = 5;
    // software-completion tag sits just above the class bits
    localparam int FPX_SWC    = FPX_NCLS;
    localparam int FPX_SUMW   = FPX_NCLS + 1;
endpackage

// File: rtl/fpx_raise_eval.sv
module fpx_raise_eval #(
    parameter int NCLS = 6
) (
    input  logic            swc,
    input  logic [NCLS-1:0] flags,
    input  logic [NCLS-1:0] ignore,
    input  logic [NCLS-1:0] enable,
    output logic [NCLS-1:0] sticky_set,
    output logic [NCLS-1:0] trap_bits,
    output logic            trap_fire
);
    logic [NCLS-1:0] kept;

    always_comb begin
        kept = flags & ~ignore;
        if (swc) begin
            // ignore mask removed before anything becomes sticky
            sticky_set = kept;
            trap_bits  = kept & enable;
        end else begin
            // every raised flag is recorded, ignore only affects trapping
            sticky_set = flags;
            trap_bits  = kept;
        end
        trap_fire = |trap_bits;
    end
endmodule

// File: rtl/fpx_onehot.sv
module fpx_onehot #(
    parameter int N = 32,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [W-1:0] idx,
    output logic [N-1:0] onehot
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign onehot[i] = (idx == W'(i));
    end
endmodule

// File: rtl/fpx_trap_unit.sv
module fpx_trap_unit
    import fpx_pkg::*;
#(
    parameter int NREGS = 32,
    parameter int WR_W  = 8,
    localparam int REG_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                raise_valid,
    input  logic                raise_swc,
    input  logic [FPX_NCLS-1:0] raise_flags,
    input  logic [FPX_NCLS-1:0] raise_ignore,
    input  logic [REG_W-1:0]    raise_reg,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [WR_W-1:0]     wr_data,
    output logic [FPX_NCLS-1:0] status_o,
    output logic [FPX_NCLS-1:0] enable_o,
    output logic                trap_valid,
    output logic [FPX_SUMW-1:0] trap_summary,
    output logic [NREGS-1:0]    trap_regmask
);
    typedef struct packed {
        logic [FPX_NCLS-1:0] status;
        logic [FPX_NCLS-1:0] enable;
        logic                trap_v;
        logic [FPX_SUMW-1:0] summ;
        logic [NREGS-1:0]    mask;
    } state_t;

    state_t state_d, state_q;

    logic [FPX_NCLS-1:0] sticky_set;
    logic [FPX_NCLS-1:0] trap_bits;
    logic                trap_fire;
    logic [NREGS-1:0]    reg_onehot;

    fpx_raise_eval #(.NCLS(FPX_NCLS)) u_eval (
        .swc        (raise_swc),
        .flags      (raise_flags),
        .ignore     (raise_ignore),
        .enable     (state_q.enable),
        .sticky_set (sticky_set),
        .trap_bits  (trap_bits),
        .trap_fire  (trap_fire)
    );

    fpx_onehot #(.N(NREGS)) u_dec (
        .idx    (raise_reg),
        .onehot (reg_onehot)
    );

    always_comb begin
        logic [FPX_NCLS-1:0] stat_base;
        logic [FPX_NCLS-1:0] en_base;
        logic                fire;

        state_d   = state_q;
        stat_base = (wr_en && !wr_sel) ? wr_data[FPX_NCLS-1:0] : state_q.status;
        en_base   = (wr_en &&  wr_sel) ? wr_data[FPX_NCLS-1:0] : state_q.enable;
        fire      = raise_valid && trap_fire;

        state_d.status = stat_base | (raise_valid ? sticky_set : '0);
        state_d.enable = en_base;
        state_d.trap_v = fire;
        state_d.summ   = fire ? {raise_swc, trap_bits} : '0;
        state_d.mask   = fire ? reg_onehot : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign status_o     = state_q.status;
    assign enable_o     = state_q.enable;
    assign trap_valid   = state_q.trap_v;
    assign trap_summary = state_q.summ;
    assign trap_regmask = state_q.mask;
endmodule

// File: rtl/fpx_trap_unit_chk.sv
module fpx_trap_unit_chk
    import fpx_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int REG_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                raise_valid,
    input logic                raise_swc,
    input logic [FPX_NCLS-1:0] raise_flags,
    input logic [FPX_NCLS-1:0] raise_ignore,
    input logic                wr_en,
    input logic [FPX_NCLS-1:0] status_o,
    input logic [FPX_NCLS-1:0] enable_o,
    input logic                trap_valid,
    input logic [FPX_SUMW-1:0] trap_summary,
    input logic [NREGS-1:0]    trap_regmask
);
    // R6: one destination bit per trap
    a_r6_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> $countones(trap_regmask) == 1);

    // R8: quiet outputs between pulses
    a_r8_idle_clean: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |-> (trap_summary == '0 && trap_regmask == '0));

    // R8: a pulse needs a raise one edge earlier
    a_r8_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
        !raise_valid |=> !trap_valid);

    // R7: zero pending flags never trap
    a_r7_zero_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_valid && raise_flags == '0) |=> !trap_valid);

    // R3: tag follows the mode of the raise
    a_r3_tag_matches_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_valid && !raise_swc) |=> !trap_summary[FPX_SWC]);

    // R5: software-completion summary stays within enabled classes
    a_r5_swc_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_valid && raise_swc) |=> (trap_summary[FPX_NCLS-1:0] & ~$past(enable_o)) == '0);

    // R2: without a write, no sticky bit drops
    a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($past(status_o) & ~status_o) == '0);

    // R4: ignored classes never become sticky through a software-completion raise
    a_r4_swc_no_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_valid && raise_swc && !wr_en) |=>
            ((status_o & ~$past(status_o)) & $past(raise_ignore)) == '0);
endmodule

bind fpx_trap_unit fpx_trap_unit_chk #(.NREGS(NREGS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .raise_valid  (raise_valid),
    .raise_swc    (raise_swc),
    .raise_flags  (raise_flags),
    .raise_ignore (raise_ignore),
    .wr_en        (wr_en),
    .status_o     (status_o),
    .enable_o     (enable_o),
    .trap_valid   (trap_valid),
    .trap_summary (trap_summary),
    .trap_regmask (trap_regmask)
);

// File: tb/fpx_trap_unit_tb_top.sv
module fpx_trap_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        raise_valid;
    logic        raise_swc;
    logic [5:0]  raise_flags;
    logic [5:0]  raise_ignore;
    logic [4:0]  raise_reg;
    logic        wr_en;
    logic        wr_sel;
    logic [7:0]  wr_data;
    logic [5:0]  status_o;
    logic [5:0]  enable_o;
    logic        trap_valid;
    logic [6:0]  trap_summary;
    logic [31:0] trap_regmask;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fpx_trap_unit dut_i (
        .clk, .rst_n, .raise_valid, .raise_swc, .raise_flags, .raise_ignore,
        .raise_reg, .wr_en, .wr_sel, .wr_data, .status_o, .enable_o,
        .trap_valid, .trap_summary, .trap_regmask
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        raise_valid = 0; raise_swc = 0; raise_flags = 0; raise_ignore = 0;
        raise_reg = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
    endtask

    // one raise; on return the trap cycle is visible (after one edge)
    task automatic raise(logic swc, logic [5:0] f, logic [5:0] ign, logic [4:0] r);
        @(negedge clk);
        raise_valid = 1; raise_swc = swc; raise_flags = f; raise_ignore = ign; raise_reg = r;
        @(negedge clk);
        idle();
    endtask

    task automatic write(logic sel, logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        idle();
    endtask

    task automatic expect_trap(string req, logic v, logic [6:0] s, logic [31:0] m);
        chk(req, "trap_valid", 64'(trap_valid), 64'(v));
        chk(req, "trap_summary", 64'(trap_summary), 64'(s));
        chk(req, "trap_regmask", 64'(trap_regmask), 64'(m));
    endtask

    task automatic t_reset();
        chk("R1", "status", 64'(status_o), 0);
        chk("R1", "enable", 64'(enable_o), 0);
        expect_trap("R1", 0, 0, 0);
    endtask

    task automatic t_plain();
        // flags overflow|inexact, ignore inexact -> status both, trap overflow
        raise(0, 6'b010100, 6'b010000, 5'd7);
        chk("R2", "status", 64'(status_o), 64'h14);
        expect_trap("R3", 1, 7'h04, 32'h1 << 7);
        chk("R6", "mask reg7", 64'(trap_regmask), 64'h80);
        @(negedge clk);
        expect_trap("R8", 0, 0, 0);
        // all ignored: status still gets them, no trap
        raise(0, 6'b001001, 6'b001001, 5'd3);
        chk("R2", "status ignored", 64'(status_o), 64'h1d);
        expect_trap("R3", 0, 0, 0);
        // integer overflow at top register
        raise(0, 6'b100000, 6'b000000, 5'd31);
        expect_trap("R6", 1, 7'h20, 32'h8000_0000);
        chk("R2", "sticky", 64'(status_o), 64'h3d);
    endtask

    task automatic t_swc();
        write(0, 8'h00);
        chk("R9", "status cleared", 64'(status_o), 0);
        write(1, 8'hc5);   // upper bits ignored -> 0x05
        chk("R9", "enable", 64'(enable_o), 64'h05);
        chk("R9", "status untouched", 64'(status_o), 0);
        // flags inv|dze|ovf, ignore dze -> status inv|ovf, gated inv|ovf & 05 = inv|ovf
        raise(1, 6'b000111, 6'b000010, 5'd12);
        chk("R4", "status", 64'(status_o), 64'h05);
        expect_trap("R5", 1, 7'h45, 32'h1 << 12);
        // survivors not enabled: status updates, no trap
        raise(1, 6'b011000, 6'b000000, 5'd1);
        chk("R5", "status gated", 64'(status_o), 64'h1d);
        expect_trap("R5", 0, 0, 0);
        // partial gating
        raise(1, 6'b000011, 6'b000000, 5'd0);
        expect_trap("R5", 1, 7'h41, 32'h1);
        chk("R4", "status", 64'(status_o), 64'h1f);
    endtask

    task automatic t_zero();
        raise(0, 6'b0, 6'b0, 5'd9);
        expect_trap("R7", 0, 0, 0);
        chk("R7", "status", 64'(status_o), 64'h1f);
        raise(1, 6'b0, 6'b111111, 5'd9);
        expect_trap("R7", 0, 0, 0);
        chk("R7", "enable", 64'(enable_o), 64'h05);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        wr_en = 1; wr_sel = 0; wr_data = 8'hff;   // writes 0x3f
        raise_valid = 0;
        @(negedge clk);
        idle();
        chk("R9", "status upper ignored", 64'(status_o), 64'h3f);
        @(negedge clk);
        wr_en = 1; wr_sel = 0; wr_data = 8'h02;
        raise_valid = 1; raise_swc = 0; raise_flags = 6'b100000; raise_ignore = 6'b100000; raise_reg = 5'd4;
        @(negedge clk);
        idle();
        chk("R10", "status merge", 64'(status_o), 64'h22);
        expect_trap("R10", 0, 0, 0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        raise_valid = 1; raise_swc = 0; raise_flags = 6'b000001; raise_ignore = 0; raise_reg = 5'd2;
        @(negedge clk);
        raise_swc = 1; raise_flags = 6'b000100; raise_reg = 5'd3;
        expect_trap("R8", 1, 7'h01, 32'h4);
        @(negedge clk);
        idle();
        expect_trap("R8", 1, 7'h44, 32'h8);
        @(negedge clk);
        expect_trap("R8", 0, 0, 0);
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_swc();
        t_zero();
        t_same_cycle();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule